// File: doc/BRIEF.md
# Backoff Spin-Lock Requester

This block obtains one shared lock bit for a single processor. The processor raises an acquire request. The block then polls the lock over a shared bus using plain reads. Polling continues for as long as the bit reads as taken. When a read finds the bit clear, the block makes one atomic swap attempt. If the swap wins, the lock is handed to the processor. If it loses, the block goes quiet for a pseudo-random number of cycles and then resumes polling.

The quiet window is drawn from a free-running 16-bit LFSR. It is limited by a per-attempt delay value. That value starts at a minimum and doubles after every lost swap until it reaches a ceiling. Agents on the same bus are given different seeds, so their retries drift apart.

When the processor gives the lock back, the block issues one plain write of false. It then returns to idle.

Top module: `backoff_lock_agent`

## Requirements
- R1: While reset is asserted and after it is released, `held` and `bus_req` are low until an acquire request is taken in idle.
- R2: While acquiring, every read (`bus_op` = 2'b00) that returns 1 (taken) is followed by another read. No swap is attempted in that case.
- R3: A swap (`bus_op` = 2'b01) is issued only as the operation directly after a read that returned 0 (free). Exactly one swap is issued per free read.
- R4: A swap that returns 0 raises `held` in the cycle after the response. While `held` is high, `bus_req` stays low.
- R5: A swap that returns 1 drops `bus_req` for exactly `(L & (D-1)) + 1` cycles. Here D is the current delay and L is the LFSR value during the response cycle. After that window the block issues a read. The LFSR is reset to `SEED` and advances every cycle as `{L[14:0], L[15]^L[13]^L[12]^L[10]}`.
- R6: D is set to `MIN_DELAY` when an acquire request is accepted. After each lost swap, D doubles if it is below `MAX_DELAY` and stays the same otherwise. Both limits are powers of two, and `MIN_DELAY` is at least 1.
- R7: `rel_req` is accepted only while `held` is high. When accepted, `held` falls in the next cycle. Exactly one write of false (`bus_op` = 2'b10) follows, and the block then returns to idle. At any other time `rel_req` causes no bus activity.
- R8: `bus_req` and `bus_op` stay stable from the moment a request is raised until its `rsp_valid`.
- R9: No response is taken and no progress is made until `bus_gnt` has been seen for the current request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_req | input | 1 | Processor asks for the lock (sampled in idle) |
| rel_req | input | 1 | Processor gives the lock back |
| held | output | 1 | Lock is owned on behalf of the processor |
| bus_req | output | 1 | Bus operation requested |
| bus_op | output | 2 | 00 read, 01 test-and-set swap, 10 write false |
| bus_gnt | input | 1 | Arbiter grant for the pending operation |
| rsp_valid | input | 1 | Response strobe for the granted operation |
| rsp_data | input | 1 | Lock value returned (prior value for a swap) |

## Verification
The release path and the acquire path can meet in one cycle. This happens when `rel_req` is already high at the moment a winning swap response arrives. The bench provokes it by raising `rel_req` together with `acq_req` and holding it through the whole acquisition, including reads of a busy lock. The design is judged correct if three things hold. No write appears before `held` has been seen. `held` stays high for exactly one cycle. Exactly one write of false then frees the lock. Apart from that, a bus model with a stealing contender checks every backoff window against an independently computed LFSR and delay sequence.

// File: rtl/backoff_lock_agent.sv
module backoff_lock_agent #(
  parameter int MIN_DELAY = 2,
  parameter int MAX_DELAY = 16,
  parameter logic [15:0] SEED = 16'h1D2B
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acq_req,
  input  logic       rel_req,
  output logic       held,
  output logic       bus_req,
  output logic [1:0] bus_op,
  input  logic       bus_gnt,
  input  logic       rsp_valid,
  input  logic       rsp_data
);
  localparam int DW = $clog2(MAX_DELAY) + 1;

  typedef enum logic [2:0] {S_IDLE, S_LURK, S_POUNCE, S_WAIT, S_HELD, S_FREE} state_t;

  state_t        state;
  logic [15:0]   lfsr;
  logic [DW-1:0] dly, cnt;
  logic          issued;
  logic          rsp_ok;

  assign rsp_ok  = rsp_valid && issued;
  assign held    = (state == S_HELD);
  assign bus_req = (state == S_LURK) || (state == S_POUNCE) || (state == S_FREE);
  assign bus_op  = (state == S_POUNCE) ? 2'b01 : (state == S_FREE) ? 2'b10 : 2'b00;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lfsr <= SEED;
    else        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   issued <= 1'b0;
    else if (!bus_req || rsp_ok)  issued <= 1'b0;
    else if (bus_gnt)             issued <= 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      dly   <= DW'(MIN_DELAY);
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: if (acq_req) begin
          dly   <= DW'(MIN_DELAY);
          state <= S_LURK;
        end
        S_LURK: if (rsp_ok && !rsp_data) state <= S_POUNCE;
        S_POUNCE: if (rsp_ok) begin
          if (!rsp_data) state <= S_HELD;
          else begin
            cnt   <= lfsr[DW-1:0] & (dly - DW'(1));
            if (dly < DW'(MAX_DELAY)) dly <= dly << 1;
            state <= S_WAIT;
          end
        end
        S_WAIT: if (cnt == '0) state <= S_LURK;
                else           cnt   <= cnt - DW'(1);
        S_HELD: if (rel_req) state <= S_FREE;
        S_FREE: if (rsp_ok) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module backoff_lock_agent_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rel_req,
  input logic       held,
  input logic       bus_req,
  input logic [1:0] bus_op,
  input logic       rsp_valid,
  input logic       rsp_data
);
  // R8
  req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !rsp_valid) |=> (bus_req && $stable(bus_op)));

  // R4
  win_to_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> $past(bus_req && bus_op == 2'b01 && rsp_valid && !rsp_data));

  // R4
  quiet_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> !bus_req);

  // R5
  lost_backoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_op == 2'b01 && rsp_valid && rsp_data) |=> !bus_req);

  // R7
  drop_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(held) |-> $past(rel_req));
endmodule

bind backoff_lock_agent backoff_lock_agent_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rel_req(rel_req), .held(held), .bus_req(bus_req),
  .bus_op(bus_op), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
);

// File: tb/test_backoff_lock_agent.sv
`timescale 1ns/1ps
module test_backoff_lock_agent;
  localparam int MIN_D = 2;
  localparam int MAX_D = 16;
  localparam logic [15:0] SEED_V = 16'hB5C3;
  localparam int NV = 5;
  // {busy reads before free, stolen swaps, busy reads after each steal, grant latency}
  localparam int VEC [NV][4] = '{
    '{0, 0, 0, 0}, '{3, 0, 0, 1}, '{1, 6, 0, 0}, '{0, 2, 2, 0}, '{2, 2, 1, 3}};
  localparam int EXP_NONE = 0, EXP_READ = 1, EXP_SWAP = 2, EXP_WRITE = 3;

  logic clk = 0, rst_n = 0;
  logic acq_req = 0, rel_req = 0;
  logic held, bus_req;
  logic [1:0] bus_op;
  logic bus_gnt = 0, rsp_valid = 0, rsp_data = 0;

  backoff_lock_agent #(.MIN_DELAY(MIN_D), .MAX_DELAY(MAX_D), .SEED(SEED_V)) i_backoff_lock_agent (
    .clk(clk), .rst_n(rst_n), .acq_req(acq_req), .rel_req(rel_req), .held(held),
    .bus_req(bus_req), .bus_op(bus_op), .bus_gnt(bus_gnt), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data));

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  logic [15:0] lfsr_m;
  int dly_m, expect_op, phase, lat_cnt, gnt_lat, steals, hold_after, other_hold;
  int reads, swaps, writes, exp_low, low_cnt;
  bit lock_reg, gnt_block, meas, held_seen;
  logic [1:0] cur_op;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk)
    if (!rst_n) lfsr_m <= SEED_V;
    else        lfsr_m <= {lfsr_m[14:0], lfsr_m[15] ^ lfsr_m[13] ^ lfsr_m[12] ^ lfsr_m[10]};

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // bus, arbiter and lock model with a stealing contender
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_gnt = 0; rsp_valid = 0; phase = 0; lat_cnt = 0; meas = 0;
    end else begin
      if (held) held_seen = 1;
      if (meas) begin
        if (!bus_req) low_cnt++;
        else begin
          chk(low_cnt == exp_low, "R5 backoff length", low_cnt, exp_low);
          chk(bus_op == 2'b00, "R5 read after backoff", bus_op, 0);
          meas = 0;
        end
      end
      case (phase)
        0: if (bus_req && !gnt_block) begin
          if (lat_cnt >= gnt_lat) begin
            bus_gnt = 1; cur_op = bus_op; phase = 1; lat_cnt = 0;
            if (expect_op == EXP_READ)  chk(bus_op == 2'b00, "R2 read while taken", bus_op, 0);
            if (expect_op == EXP_SWAP)  chk(bus_op == 2'b01, "R3 swap after free read", bus_op, 1);
            if (expect_op == EXP_WRITE) chk(bus_op == 2'b10, "R7 write on release", bus_op, 2);
            if (bus_op == 2'b10) chk(held_seen, "R7 no write before held", 0, 1);
          end else lat_cnt++;
        end
        1: begin
          bus_gnt = 0; rsp_valid = 1;
          if (cur_op == 2'b00) begin
            reads++;
            if (other_hold > 0) begin other_hold--; rsp_data = 1; end
            else rsp_data = lock_reg;
            expect_op = rsp_data ? EXP_READ : EXP_SWAP;
          end else if (cur_op == 2'b01) begin
            swaps++;
            if (steals > 0) begin
              steals--; other_hold = hold_after; rsp_data = 1;
            end else begin
              rsp_data = lock_reg; lock_reg = 1;
            end
            if (rsp_data) begin
              exp_low = int'(lfsr_m & 16'(dly_m - 1)) + 1;
              low_cnt = 0; meas = 1;
              if (dly_m < MAX_D) dly_m = dly_m * 2;
              expect_op = EXP_READ;
            end else expect_op = EXP_WRITE;
          end else begin
            writes++; rsp_data = 0; lock_reg = 0; expect_op = EXP_NONE;
          end
          phase = 2;
        end
        default: begin rsp_valid = 0; phase = 0; end
      endcase
    end
  end

  task automatic setup(input int pre, input int st, input int ha, input int lat);
    other_hold = pre; steals = st; hold_after = ha; gnt_lat = lat;
    reads = 0; swaps = 0; writes = 0; dly_m = MIN_D; expect_op = EXP_READ; held_seen = 0;
  endtask

  task automatic acquire();
    @(negedge clk) acq_req = 1;
    @(negedge clk) acq_req = 0;
    while (!held) @(negedge clk);
  endtask

  task automatic release_lock();
    @(negedge clk) rel_req = 1;
    @(negedge clk) rel_req = 0;
    chk(!held, "R7 held falls after release", held, 0);
    while (bus_req || held) @(negedge clk);
    chk(writes == 1, "R7 single write", writes, 1);
    chk(lock_reg == 0, "R7 lock freed", lock_reg, 0);
    chk(!bus_req && !held, "R1 back to idle", bus_req, 0);
  endtask

  initial begin
    lock_reg = 0; gnt_block = 0; setup(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk(!held && !bus_req, "R1 reset state", {held, bus_req}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!held && !bus_req, "R1 idle after reset", {held, bus_req}, 0);

    for (int v = 0; v < NV; v++) begin
      setup(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      acquire();
      chk(reads == VEC[v][0] + 1 + VEC[v][1] * (VEC[v][2] + 1), "R2 read count", reads,
          VEC[v][0] + 1 + VEC[v][1] * (VEC[v][2] + 1));
      chk(swaps == VEC[v][1] + 1, "R3 swap count", swaps, VEC[v][1] + 1);
      chk(lock_reg == 1, "R4 lock won", lock_reg, 1);
      chk(dly_m == ((VEC[v][1] >= 3) ? MAX_D : MIN_D << VEC[v][1]), "R6 delay sequence", dly_m,
          (VEC[v][1] >= 3) ? MAX_D : MIN_D << VEC[v][1]);
      @(negedge clk);
      chk(held && !bus_req, "R4 held and quiet", {held, bus_req}, 2);
      release_lock();
    end

    // R7: release while idle is ignored
    setup(0, 0, 0, 0);
    @(negedge clk) rel_req = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!bus_req && !held, "R7 release ignored in idle", bus_req, 0);
    end
    rel_req = 0;
    chk(writes == 0, "R7 no write from idle release", writes, 0);

    // R9: no progress without grant; R8 request held steady
    setup(0, 0, 0, 0);
    gnt_block = 1;
    @(negedge clk) acq_req = 1;
    @(negedge clk) acq_req = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(bus_req && bus_op == 2'b00 && !held, "R9 waits for grant", {bus_req, bus_op}, 4);
    end
    gnt_block = 0;
    while (!held) @(negedge clk);
    chk(reads == 1 && swaps == 1, "R9 proceeds after grant", reads + swaps, 2);
    release_lock();

    // R7: release and acquire meet in one cycle
    setup(2, 1, 1, 0);
    @(negedge clk) begin acq_req = 1; rel_req = 1; end
    @(negedge clk) acq_req = 0;
    while (!held) @(negedge clk);
    @(negedge clk);
    chk(!held && bus_req && bus_op == 2'b10, "R7 concurrent release", {held, bus_req, bus_op}, 6);
    while (bus_req) @(negedge clk);
    rel_req = 0;
    chk(writes == 1 && lock_reg == 0, "R7 concurrent single write", writes, 1);
    chk(swaps == 2, "R3 concurrent swaps", swaps, 2);

    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule